// File: doc/BRIEF.md
# Multi-Channel DMA Bus Arbiter

This block decides, cycle by cycle, who owns a shared system bus: the CPU or one of several DMA channels. Each channel asks for the bus with a request line. A mode bit sets each channel to one of two modes. In burst mode the channel keeps the bus for consecutive transfer units. In cycle-steal mode it takes one transfer unit at a time. A global select picks the arbitration style: a fixed ranking, where a lower channel index always wins, or a rotating ranking.

The grant is held in a register. A grant to a channel lasts until that channel pulses its unit-done line, which marks the end of one transfer unit. At that boundary the arbiter picks the next owner. A CPU grant lasts one cycle, and then the arbiter decides again.

A cycle-steal channel normally hands the bus back to the CPU after each unit. If a burst channel is waiting, it hands the bus to that burst channel instead. So a stealing channel and a bursting channel alternate without releasing the bus. The rotating ranking expects all channels to share one mode. If the mode bits disagree, an error flag goes high and every channel is treated as cycle-steal. A bus-held flag tells other bus masters that a DMA channel owns the bus.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset the CPU holds the grant, no channel grant bit is set, bus_held is low and the ranking pointer starts at channel 0.
- R2: In fixed mode, when the CPU owns the bus or a burst-mode channel finishes a unit, the next owner is the requesting channel with the lowest index (channel 0 is highest). A burst channel that still requests keeps the bus when no lower index requests.
- R3: While a channel owns the bus, the grant does not change until that channel's unit_done bit is high at a clock edge. The new grant appears one cycle after that edge.
- R4: At the unit boundary of a bursting channel, a requesting channel of lower index takes the bus. The preempted burst gets the bus back at the first boundary where no lower-index channel requests. The bus does not pass through the CPU in between.
- R5: When a cycle-steal channel (mode bit 0) finishes a unit and some burst-mode channel (mode bit 1) requests, the bus goes to the highest-ranked requesting burst channel, not to the CPU. A steal channel and a burst channel therefore alternate unit by unit.
- R6: When a cycle-steal channel finishes a unit and no burst-mode channel requests, the CPU owns the bus for exactly one cycle. Then any pending request is granted.
- R7: With rr_mode high, the search for the next owner starts at the channel after the one most recently granted, wrapping from the last index to 0. The served channel therefore ranks lowest.
- R8: With rr_mode high and the burst_mode bits not all equal, mode_err is high and every channel acts as cycle-steal. With rr_mode low, or with equal bits, mode_err is low.
- R9: At a decision point with no request pending, the grant goes to the CPU and bus_held goes low.
- R10: Exactly one of grant_ch bits and grant_cpu is high in every cycle, and bus_held is high exactly when a channel bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N | Per-channel bus request |
| burst_mode | input | N | Per-channel mode: 1 burst, 0 cycle-steal |
| unit_done | input | N | Per-channel pulse ending one transfer unit |
| rr_mode | input | 1 | 1 rotating ranking, 0 fixed ranking |
| grant_ch | output | N | One-hot channel grant (registered) |
| grant_cpu | output | 1 | CPU owns the bus (registered) |
| bus_held | output | 1 | A DMA channel holds the bus |
| mode_err | output | 1 | Rotating ranking selected with mixed channel modes |

## Verification
The assertions check the following on every cycle:
- exactly one owner at all times;
- agreement between bus_held and the channel grant;
- a channel grant held steady until its own unit boundary;
- a one-cycle-only CPU slot when a request is pending;
- fall-back to the CPU when idle;
- a stealing channel passing the bus to a waiting burst channel.

Only the bench scenarios can show that the ranking picks the right winner: the lowest index across all request patterns, preemption followed by resumption, rotation order in the rotating ranking, and the cycle-steal fall-back when modes are mixed.

// File: rtl/dab_pkg.sv
// Package: shared helpers for the DMA bus arbiter.
// Assumes the channel count is at least 1.
package dab_pkg;
    // Width needed to index n channels (never below 1).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dab_mode_qual.sv
// Module: dab_mode_qual
// Works out each channel's effective transfer mode. In the rotating
// ranking the channels must share one mode. When they do not, the error
// flag goes high and every channel is forced to cycle-steal.
// Assumes burst_mode is stable while it is in use.
module dab_mode_qual #(
    parameter int N = 4
) (
    input  logic [N-1:0] burst_mode,
    input  logic         rr_mode,
    output logic [N-1:0] eff_burst,
    output logic         mode_err
);
    logic mixed;

    // Detect disagreement among the mode bits and mask them when needed.
    always_comb begin
        mixed     = (|burst_mode) && !(&burst_mode);
        mode_err  = rr_mode && mixed;
        eff_burst = mode_err ? '0 : burst_mode;
    end
endmodule

// File: rtl/dab_picker.sv
// Module: dab_picker
// Picks one channel out of a candidate mask. In fixed mode the lowest
// index wins. In rotating mode the search starts at ptr and wraps.
// Assumes ptr < N.
module dab_picker #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic          rr_en,
    input  logic [CW-1:0] ptr,
    output logic          found,
    output logic [CW-1:0] idx
);
    int j;

    // Scan from the lowest rank to the highest so the top-ranked candidate is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        j     = 0;
        for (int off = N - 1; off >= 0; off--) begin
            j = rr_en ? ((int'(ptr) + off) % N) : off;
            if (cand[j]) begin
                found = 1'b1;
                idx   = CW'(j);
            end
        end
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
// Module: dma_bus_arbiter
// Top-level bus arbiter for N DMA channels and the CPU. The owner is held
// in a register.
// - A channel's grant ends only when that channel pulses unit_done.
// - A CPU slot lasts one cycle.
// - A cycle-steal channel hands the bus to a waiting burst channel if
//   there is one, and otherwise to the CPU.
// - After the CPU or a burst channel, any requester may win.
// Assumes a channel keeps req high until its last unit is done, and that
// unit_done pulses only for the current owner.
module dma_bus_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] burst_mode,
    input  logic [N-1:0] unit_done,
    input  logic         rr_mode,
    output logic [N-1:0] grant_ch,
    output logic         grant_cpu,
    output logic         bus_held,
    output logic         mode_err
);
    import dab_pkg::*;
    localparam int CW = idx_width(N);

    logic [N-1:0]  grant_q;
    logic          cpu_q;
    logic [CW-1:0] ptr_q;
    logic [N-1:0]  eff_burst;
    logic          all_found, burst_found;
    logic [CW-1:0] all_idx, burst_idx;
    logic          boundary, cur_steal, take;
    logic [CW-1:0] nidx;

    dab_mode_qual #(.N(N)) u_mode (
        .burst_mode (burst_mode),
        .rr_mode    (rr_mode),
        .eff_burst  (eff_burst),
        .mode_err   (mode_err)
    );

    dab_picker #(.N(N), .CW(CW)) u_pick_all (
        .cand  (req),
        .rr_en (rr_mode),
        .ptr   (ptr_q),
        .found (all_found),
        .idx   (all_idx)
    );

    dab_picker #(.N(N), .CW(CW)) u_pick_burst (
        .cand  (req & eff_burst),
        .rr_en (rr_mode),
        .ptr   (ptr_q),
        .found (burst_found),
        .idx   (burst_idx)
    );

    // Choose the candidate pool: burst channels only after a steal unit, otherwise all requesters.
    always_comb begin
        boundary  = cpu_q || (|(grant_q & unit_done));
        cur_steal = |(grant_q & ~eff_burst);
        if (!cpu_q && cur_steal) begin
            take = burst_found;
            nidx = burst_idx;
        end else begin
            take = all_found;
            nidx = all_idx;
        end
    end

    // Owner register and rotation pointer, updated only at decision points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            cpu_q   <= 1'b1;
            ptr_q   <= '0;
        end else if (boundary) begin
            if (take) begin
                grant_q <= N'(1) << nidx;
                cpu_q   <= 1'b0;
                ptr_q   <= (int'(nidx) == N - 1) ? '0 : nidx + CW'(1);
            end else begin
                grant_q <= '0;
                cpu_q   <= 1'b1;
            end
        end
    end

    assign grant_ch  = grant_q;
    assign grant_cpu = cpu_q;
    assign bus_held  = !cpu_q;
endmodule

// File: rtl/dab_checker.sv
// Module: dab_checker
// Checks the arbiter's properties on every cycle. It is attached to the
// top module with a bind statement. Assumes the stimulus follows the
// top module's stated assumptions.
module dab_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] burst_mode,
    input logic [N-1:0] unit_done,
    input logic         rr_mode,
    input logic [N-1:0] grant_ch,
    input logic         grant_cpu,
    input logic         bus_held,
    input logic         mode_err
);
    // R10: a single owner in every cycle
    assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({grant_ch, grant_cpu}) == 1);

    // R10: bus_held follows a channel grant
    assert_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_held == (|grant_ch));

    // R3: a channel grant holds until that channel's unit ends
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_cpu && !(|(grant_ch & unit_done))) |=> $stable(grant_ch));

    // R6: a CPU slot with a pending request lasts only one cycle
    assert_cpu_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_cpu && (|req)) |=> !grant_cpu);

    // R9: no request at a decision point returns the bus to the CPU
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_cpu || (|(grant_ch & unit_done))) && (req == '0)) |=> grant_cpu);

    // R5: a finished steal unit with a waiting burst channel stays with DMA
    assert_steal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode && (|(grant_ch & unit_done & ~burst_mode)) && (|(req & burst_mode)))
        |=> !grant_cpu);

    // R8: the error flag needs the rotating ranking
    assert_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> rr_mode);

    // R8: uniform modes never raise the error flag
    assert_err_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&burst_mode) || (burst_mode == '0)) |-> !mode_err);
endmodule

bind dma_bus_arbiter dab_checker #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .burst_mode (burst_mode),
    .unit_done  (unit_done),
    .rr_mode    (rr_mode),
    .grant_ch   (grant_ch),
    .grant_cpu  (grant_cpu),
    .bus_held   (bus_held),
    .mode_err   (mode_err)
);

// File: tb/dma_bus_arbiter_tb.sv
// Bench for dma_bus_arbiter with three channels. Inputs change 2 ns after
// a rising edge. Outputs are checked 2 ns after the next rising edge,
// when the registered grant reflects the inputs that were just applied.
module dma_bus_arbiter_tb;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] burst_mode = '0;
    logic [N-1:0] unit_done = '0;
    logic         rr_mode = 1'b0;
    logic [N-1:0] grant_ch;
    logic         grant_cpu;
    logic         bus_held;
    logic         mode_err;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dma_bus_arbiter #(.N(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .burst_mode (burst_mode),
        .unit_done  (unit_done),
        .rr_mode    (rr_mode),
        .grant_ch   (grant_ch),
        .grant_cpu  (grant_cpu),
        .bus_held   (bus_held),
        .mode_err   (mode_err)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Expected owner: a one-hot channel mask, or 0 for the CPU.
    task automatic chk(input logic [N-1:0] exp, input string tag);
        total++;
        if (grant_ch !== exp || grant_cpu !== (exp == '0) || bus_held !== (exp != '0)) begin
            bad++;
            $display("FAIL %s: grant=%b cpu=%b held=%b expected grant=%b cpu=%b held=%b",
                     tag, grant_ch, grant_cpu, bus_held, exp, exp == '0, exp != '0);
        end
    endtask

    task automatic chk_err(input logic exp, input string tag);
        total++;
        if (mode_err !== exp) begin
            bad++;
            $display("FAIL %s: mode_err=%b expected %b", tag, mode_err, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; unit_done = '0; rr_mode = 1'b0; burst_mode = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // One unit boundary for the given owner mask, with a new request set.
    task automatic unit_end(input logic [N-1:0] who, input logic [N-1:0] r);
        req = r; unit_done = who;
        tick();
        unit_done = '0;
    endtask

    initial begin
        do_reset();
        chk(3'b000, "R1 reset owner");
        chk_err(1'b0, "R1 reset error flag");

        // R2: from the CPU, every request pattern goes to the lowest index
        for (int p = 1; p < 8; p++) begin
            logic [N-1:0] e;
            do_reset();
            burst_mode = 3'b111;
            req = N'(p);
            e = N'(p) & (~N'(p) + N'(1));
            tick();
            chk(e, "R2 lowest index wins");
            unit_end(e, '0);
            chk(3'b000, "R9 idle returns to cpu");
        end

        // R3/R4: preemption of a burst, then resumption
        do_reset();
        burst_mode = 3'b111; req = 3'b010; tick();
        chk(3'b010, "R2 ch1 granted");
        req = 3'b011; tick();
        chk(3'b010, "R3 held without unit_done");
        unit_end(3'b010, 3'b011);
        chk(3'b001, "R4 ch0 preempts");
        unit_end(3'b001, 3'b011);
        chk(3'b001, "R2 ch0 burst continues");
        unit_end(3'b001, 3'b010);
        chk(3'b010, "R4 ch1 resumes");
        unit_end(3'b010, 3'b000);
        chk(3'b000, "R9 cpu after all done");

        // R2: competing bursts finish one after another without the CPU
        do_reset();
        burst_mode = 3'b111; req = 3'b110; tick();
        chk(3'b010, "R2 ch1 before ch2");
        unit_end(3'b010, 3'b100);
        chk(3'b100, "R4 ch2 directly after ch1");

        // R5/R6: steal ch0 and burst ch1 alternate, then steal yields to the cpu
        do_reset();
        burst_mode = 3'b010; req = 3'b011; tick();
        chk(3'b001, "R2 ch0 first");
        unit_end(3'b001, 3'b011);
        chk(3'b010, "R5 steal hands to burst");
        unit_end(3'b010, 3'b011);
        chk(3'b001, "R2 back to ch0");
        unit_end(3'b001, 3'b011);
        chk(3'b010, "R5 alternation again");
        unit_end(3'b010, 3'b001);
        chk(3'b001, "R2 ch0 alone");
        unit_end(3'b001, 3'b001);
        chk(3'b000, "R6 steal yields to cpu");
        tick();
        chk(3'b001, "R6 cpu slot one cycle");
        unit_end(3'b001, 3'b000);
        chk(3'b000, "R9 idle");

        // R7: rotating ranking with all burst channels
        do_reset();
        rr_mode = 1'b1; burst_mode = 3'b111; req = 3'b111; tick();
        chk(3'b001, "R7 start at ch0");
        chk_err(1'b0, "R8 uniform modes no error");
        unit_end(3'b001, 3'b111);
        chk(3'b010, "R7 rotate to ch1");
        unit_end(3'b010, 3'b111);
        chk(3'b100, "R7 rotate to ch2");
        unit_end(3'b100, 3'b111);
        chk(3'b001, "R7 wrap to ch0");
        unit_end(3'b001, 3'b101);
        chk(3'b100, "R7 skip idle ch1");
        unit_end(3'b100, 3'b101);
        chk(3'b001, "R7 wrap after ch2");

        // R8: mixed modes under the rotating ranking act as cycle-steal
        do_reset();
        rr_mode = 1'b1; burst_mode = 3'b001; req = 3'b011;
        #1;
        chk_err(1'b1, "R8 mixed modes flagged");
        tick();
        chk(3'b001, "R7 ch0 first");
        unit_end(3'b001, 3'b011);
        chk(3'b000, "R8 burst ch0 treated as steal");
        tick();
        chk(3'b010, "R8 rotation gives ch1");
        rr_mode = 1'b0;
        #1;
        chk_err(1'b0, "R8 fixed mode no error");
        unit_end(3'b010, 3'b011);
        chk(3'b001, "R5 fixed steal ch1 hands to burst ch0");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule